// File: doc/BRIEF.md
# Serial Wiper Step Controller

This block produces fine-tuning steps for a digitally controlled resistor wiper. The command decoder upstream accepts an increment/decrement command and acknowledges it on a two-wire serial bus. It then pulses `arm`, and this block takes over the bus lines. From then on, the clock line no longer shifts serial data. Each high phase of the clock line becomes one wiper step. The level of the data line, sampled when the clock line rises, selects the direction: high moves the wiper up, low moves it down. Up and down steps may be mixed freely within one session.

The session ends on a bus stop or start condition: the data line changes while the clock line is held high. Ending a session never produces a step. Both bus lines are brought into the faster system clock through a synchroniser chain. The outputs are single-cycle `step_up` and `step_dn` pulses in the system clock domain, meant to drive a wiper counter that sits outside this block.

The controller is a four-state machine:
- `ST_IDLE`: waits for `arm`.
- `ST_SETTLE`: entered when `arm` arrives while the clock line is still high from the acknowledge. It waits for the clock line to fall.
- `ST_LOW`: the clock line is low and a rising edge is expected.
- `ST_HIGH`: a step has been issued and the clock line is high.

The transitions are:
- arm with the line high: `ST_IDLE`→`ST_SETTLE`.
- arm with the line low: `ST_IDLE`→`ST_LOW`.
- clock line falls: `ST_SETTLE`→`ST_LOW`.
- clock line rises, which issues a step: `ST_LOW`→`ST_HIGH`.
- clock line falls: `ST_HIGH`→`ST_LOW`.
- stop or start condition: `ST_SETTLE` or `ST_HIGH` goes to `ST_IDLE`.

Top module: `wiper_step_ctrl`

## Requirements
- R1: After reset, `active`, `step_up` and `step_dn` are all 0.
- R2: A one-cycle `arm` pulse while not active sets `active` to 1 from the next system clock cycle on.
- R3: While `active` is 0, clock line activity produces no step pulse.
- R4: Each high phase of the clock line during a session produces exactly one step pulse, one system cycle wide. The pulse is visible after the third system clock edge following the rise of the clock line pin: two synchroniser stages plus one output register.
- R5: A data line level of 1 at the clock line rise produces a `step_up` pulse.
- R6: A data line level of 0 at the clock line rise produces a `step_dn` pulse.
- R7: Up and down steps mixed in any order within one session are each counted on the matching output.
- R8: Data line changes while the clock line is low neither produce a step nor end the session.
- R9: A rise of the data line while the clock line is high (stop) clears `active` and produces no step of its own.
- R10: A fall of the data line while the clock line is high (start) clears `active` and produces no step of its own.
- R11: If the clock line is high when `arm` arrives, that high phase gives no step; stepping starts with the next rise.
- R12: `step_up` and `step_dn` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | One-cycle pulse from the decoder: step command acknowledged |
| scl_in | input | 1 | Serial bus clock line, asynchronous |
| sda_in | input | 1 | Serial bus data line, asynchronous |
| active | output | 1 | High while the stepping session runs |
| step_up | output | 1 | One-cycle pulse: move the wiper one segment up |
| step_dn | output | 1 | One-cycle pulse: move the wiper one segment down |

## Verification
The main function is tried with four kinds of pattern:
- Directed single pulses of each direction pin down the direction mapping and the exact three-cycle latency.
- A long seeded random session mixes directions and toggles the data line during the low phases. Its up and down totals separate a correct per-pulse count from double counting, missed pulses, or sampling the data line at the wrong moment.
- Clock pulses sent while idle, and an arm during a high clock line, show that only acknowledged rising edges count.
- Closing a session by stop and by start shows that each ends the session without adding a step.

// File: rtl/wiper_step_pkg.sv
package wiper_step_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,  // no session
        ST_SETTLE = 2'd1,  // armed while clock line high, wait for fall
        ST_LOW    = 2'd2,  // clock line low, ready for a rise
        ST_HIGH   = 2'd3   // step issued, clock line high
    } step_state_t;

    // Events derived from the synchronised lines
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic bus_cond;   // data edge with clock line stable high
        logic scl_lvl;
        logic sda_lvl;
    } line_events_t;

endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
    parameter int   STAGES    = 2,
    parameter int   WIDTH     = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= {WIDTH{RESET_VAL}};
                end else begin
                    if (g == 0) begin
                        chain[g] <= din;
                    end else begin
                        chain[g] <= chain[(g == 0) ? 0 : g - 1];
                    end
                end
            end
        end
    endgenerate

    assign dout = chain[LAST];

endmodule

// File: rtl/line_events.sv
module line_events
    import wiper_step_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         scl_s,
    input  logic         sda_s,
    output line_events_t ev
);

    logic scl_d;
    logic sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        ev.scl_rise = scl_s & ~scl_d;
        ev.scl_fall = ~scl_s & scl_d;
        // a data edge only counts as stop/start with the clock line high both cycles
        ev.bus_cond = (sda_s ^ sda_d) & scl_s & scl_d;
        ev.scl_lvl  = scl_s;
        ev.sda_lvl  = sda_s;
    end

endmodule

// File: rtl/step_fsm.sv
module step_fsm
    import wiper_step_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         arm,
    input  line_events_t ev,
    output logic         active,
    output logic         step_up,
    output logic         step_dn
);

    step_state_t state;
    step_state_t state_nxt;
    logic        fire;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // next state and step decision
    always_comb begin
        state_nxt = state;
        fire      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (arm) begin
                    state_nxt = ev.scl_lvl ? ST_SETTLE : ST_LOW;
                end
            end
            ST_SETTLE: begin
                if (ev.bus_cond) begin
                    state_nxt = ST_IDLE;
                end else if (ev.scl_fall) begin
                    state_nxt = ST_LOW;
                end
            end
            ST_LOW: begin
                if (ev.scl_rise) begin
                    fire      = 1'b1;
                    state_nxt = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (ev.bus_cond) begin
                    state_nxt = ST_IDLE;
                end else if (ev.scl_fall) begin
                    state_nxt = ST_LOW;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active  <= 1'b0;
            step_up <= 1'b0;
            step_dn <= 1'b0;
        end else begin
            active  <= (state_nxt != ST_IDLE);
            step_up <= fire & ev.sda_lvl;
            step_dn <= fire & ~ev.sda_lvl;
        end
    end

endmodule

// File: rtl/wiper_step_ctrl.sv
module wiper_step_ctrl
    import wiper_step_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic scl_in,
    input  logic sda_in,
    output logic active,
    output logic step_up,
    output logic step_dn
);

    localparam int LINES = 2;

    logic [LINES-1:0] lines_s;
    line_events_t     ev;

    bus_sync #(
        .STAGES    (SYNC_STAGES),
        .WIDTH     (LINES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_in, sda_in}),
        .dout  (lines_s)
    );

    line_events u_events (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (lines_s[1]),
        .sda_s (lines_s[0]),
        .ev    (ev)
    );

    step_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .ev      (ev),
        .active  (active),
        .step_up (step_up),
        .step_dn (step_dn)
    );

endmodule

// File: rtl/wiper_step_checker.sv
module wiper_step_checker (
    input logic clk,
    input logic rst_n,
    input logic arm,
    input logic active,
    input logic step_up,
    input logic step_dn
);

    AST_NO_DUAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up && step_dn));                                   // R12
    AST_UP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        step_up |=> !step_up);                                    // R4
    AST_DN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        step_dn |=> !step_dn);                                    // R4
    AST_STEP_IN_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up || step_dn) |-> active);                         // R3
    AST_ARM_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !active) |=> active);                             // R2
    AST_END_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> (!step_up && !step_dn));                // R9

endmodule

bind wiper_step_ctrl wiper_step_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm),
    .active  (active),
    .step_up (step_up),
    .step_dn (step_dn)
);

// File: tb/tb_wiper_step_ctrl.sv
module tb_wiper_step_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 1'b0;
    logic scl_in = 1'b1;
    logic sda_in = 1'b1;
    logic active, step_up, step_dn;

    int checks = 0;
    int errors = 0;
    int n_up = 0;
    int n_dn = 0;
    int exp_up = 0;
    int exp_dn = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wiper_step_ctrl dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .scl_in  (scl_in),
        .sda_in  (sda_in),
        .active  (active),
        .step_up (step_up),
        .step_dn (step_dn)
    );

    // step counters, sampled away from the active edge
    always @(negedge clk) begin
        if (step_up) n_up++;
        if (step_dn) n_dn++;
    end

    function automatic bit dir_is_up(input bit sda_level);
        return sda_level;   // level 1 at the rise means up
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_arm();
        @(negedge clk);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    // one clock line pulse with the given data level at the rise
    task automatic pulse(input bit lvl, input bit expect_step);
        @(negedge clk);
        sda_in = lvl;
        wait_cyc(4);
        scl_in = 1'b1;
        wait_cyc(6);
        scl_in = 1'b0;
        wait_cyc(6);
        if (expect_step) begin
            if (dir_is_up(lvl)) exp_up++;
            else                exp_dn++;
        end
    endtask

    task automatic check_counts(input string tag);
        check(n_up == exp_up, {tag, " up count"}, n_up, exp_up);
        check(n_dn == exp_dn, {tag, " down count"}, n_dn, exp_dn);
    endtask

    // stop (rise=1) or start (rise=0) condition, clock line left high
    task automatic bus_condition(input bit rising);
        @(negedge clk);
        scl_in = 1'b0;
        sda_in = ~rising;
        wait_cyc(4);
        scl_in = 1'b1;
        wait_cyc(6);
        sda_in = rising;
        wait_cyc(6);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        // R1 reset state
        check(active == 1'b0, "R1 active", active, 0);
        check(step_up == 1'b0 && step_dn == 1'b0, "R1 steps", {step_up, step_dn}, 0);

        // R3 pulses while idle are ignored
        scl_in = 1'b0;
        for (int i = 0; i < 4; i++) pulse(i[0], 1'b0);
        check_counts("R3 idle");
        check(active == 1'b0, "R3 still idle", active, 0);

        // R2 arm with clock line low
        @(negedge clk);
        arm = 1'b1;
        @(posedge clk);
        #1;
        check(active == 1'b1, "R2 active after arm", active, 1);
        @(negedge clk);
        arm = 1'b0;

        // R4 latency and width, R5 direction up
        sda_in = 1'b1;
        wait_cyc(4);
        scl_in = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        check(step_up == 1'b0, "R4 no pulse before third edge", step_up, 0);
        @(posedge clk); #1;
        check(step_up == 1'b1, "R5 R4 up pulse at third edge", step_up, 1);
        check(step_dn == 1'b0, "R5 no down pulse", step_dn, 0);
        @(posedge clk); #1;
        check(step_up == 1'b0, "R4 pulse one cycle wide", step_up, 0);
        exp_up++;
        wait_cyc(4);
        scl_in = 1'b0;
        wait_cyc(6);

        // R6 direction down
        pulse(1'b0, 1'b1);
        check_counts("R6 single down");

        // R8 data toggles in low phase
        for (int i = 0; i < 6; i++) begin
            sda_in = ~sda_in;
            wait_cyc(3);
        end
        check_counts("R8 low-phase toggles");
        check(active == 1'b1, "R8 session kept", active, 1);

        // R7 random mixed session
        for (int i = 0; i < 60; i++) begin
            bit lvl;
            lvl = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 3) == 0) begin
                sda_in = ~lvl;
                wait_cyc(2);
            end
            pulse(lvl, 1'b1);
        end
        check_counts("R7 random mix");

        // R9 stop: down pulse at rise, then data rises during high phase
        bus_condition(1'b1);
        exp_dn++;
        check_counts("R9 stop adds no step");
        check(active == 1'b0, "R9 stop ends session", active, 0);

        // R11 arm while clock line high
        do_arm();
        check(active == 1'b1, "R11 armed", active, 1);
        wait_cyc(8);
        check_counts("R11 high phase at arm");
        @(negedge clk);
        scl_in = 1'b0;
        wait_cyc(6);
        pulse(1'b1, 1'b1);
        check_counts("R11 first rise steps");

        // R10 start: up pulse at rise, then data falls during high phase
        bus_condition(1'b0);
        exp_up++;
        check_counts("R10 start adds no step");
        check(active == 1'b0, "R10 start ends session", active, 0);

        // R3 after the session, again ignored
        scl_in = 1'b0;
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b0);
        check_counts("R3 after end");

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(negedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog all-requirements actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule